// File: doc/BRIEF.md
# Chiplet control register file

This block is a bank of twelve 64-bit registers that configure one on-chip unit. Software reaches it through a single-master request/response port that carries byte addresses. Every access moves a full 64-bit word, and the word index is the byte address shifted right by three. Data bits cross the port unchanged. Register bit 0 is the most significant bit of the 64-bit bus word (bus bit 63).

Eight of the words have three addresses each: a plain address that replaces the word, a set alias that ORs the written data in, and a clear alias that removes every bit set in the written data. These eight are six control words and two configuration words. The aliases let software flip individual bits with one write and no read-modify-write. The aliases can only be written. The other four words are plain read/write: status, mask, protect-mode and lock.

Each accepted request is acknowledged on the following cycle. The acknowledge returns read data and an error flag. The port takes one request at a time.

Top module: `chiplet_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears all twelve words to zero, drops `rsp_valid` and raises `req_ready`.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the next cycle, and `req_ready` is low during that cycle.
- R3: The word index is `req_addr[15:3]`. Bits [2:0] of the address have no effect on which word is accessed.
- R4: Control word n (n = 0..5) is at index n. A plain write replaces the word, and a read returns it. No word changes in a cycle without an accepted write to one of its addresses.
- R5: A write to index n+0x10 ORs the data into control word n. A write to index 0x18+m ORs the data into configuration word m.
- R6: A write to index n+0x20 clears in control word n every bit that is 1 in the data. A write to index 0x28+m does the same for configuration word m.
- R7: Configuration words 0 and 1 are at indices 0x08 and 0x09. A plain write replaces the word, and a read returns it.
- R8: Four plain read/write words sit at fixed indices: status at 0x100, mask at 0x101, protect-mode at 0x3FE and lock at 0x3FF.
- R9: A read of any set or clear alias returns all ones with `rsp_err`=1 and changes no word.
- R10: An access to any index not listed above changes no word and sets `rsp_err`=1. A read of such an index returns all ones. Successful accesses return `rsp_err`=0. A write acknowledge carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; bits [15:3] form the word index |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Acknowledge, one cycle after acceptance |
| rsp_rdata | output | 64 | Read data (zero for writes, all ones on a failed read) |
| rsp_err | output | 1 | Access hit an undecoded index or read a write-only alias |

## Verification
Some properties are checked on every cycle:
- the handshake timing: acknowledge follows acceptance, and ready is low during the acknowledge;
- the state is unchanged across any read or any idle cycle;
- a failed read returns all ones;
- reset clears the bank.

Other behaviour only the bench scenarios can show, and it checks each against its own model of the bank:
- the merge arithmetic of the set and clear aliases;
- the exact index of each word, including a full sweep of every index up to 0x3FF and indices above it;
- that the low address bits are ignored.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int DATA_W      = 64;
    localparam int ADDR_W      = 16;
    localparam int LSB_W       = 3;
    localparam int IDX_W       = ADDR_W - LSB_W;
    localparam int NUM_CTRL    = 6;
    localparam int NUM_CFG     = 2;
    localparam int NUM_ALIASED = NUM_CTRL + NUM_CFG;
    localparam int NUM_PLAIN   = 4;
    localparam int NUM_WORDS   = NUM_ALIASED + NUM_PLAIN;

    localparam int CTRL_BASE   = 'h000;
    localparam int CFG_BASE    = 'h008;
    localparam int SET_OFS     = 'h010;
    localparam int CLR_OFS     = 'h020;
    localparam int STAT_IDX    = 'h100;
    localparam int MASK_IDX    = 'h101;
    localparam int PROT_IDX    = 'h3FE;
    localparam int LOCK_IDX    = 'h3FF;

    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [NUM_WORDS-1:0] wsel_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2
    } wr_op_e;

    typedef struct packed {
        logic   hit;
        logic   wr_only;
        wr_op_e op;
        wsel_t  sel;
    } dec_t;

    function automatic idx_t aliased_index(input int k);
        if (k < NUM_CTRL)
            return idx_t'(CTRL_BASE + k);
        return idx_t'(CFG_BASE + k - NUM_CTRL);
    endfunction

    function automatic idx_t plain_index(input int k);
        case (k)
            0:       return idx_t'(STAT_IDX);
            1:       return idx_t'(MASK_IDX);
            2:       return idx_t'(PROT_IDX);
            default: return idx_t'(LOCK_IDX);
        endcase
    endfunction

    function automatic word_t merge(input word_t cur, input word_t wd, input wr_op_e op);
        case (op)
            OP_SET:  return cur | wd;
            OP_CLR:  return cur & ~wd;
            default: return wd;
        endcase
    endfunction

endpackage

// File: rtl/crf_decode.sv
module crf_decode
    import crf_pkg::*;
(
    input  idx_t idx,
    output dec_t dec
);

    always_comb begin
        dec     = '0;
        dec.op  = OP_WRITE;
        for (int k = 0; k < NUM_ALIASED; k++) begin
            if (idx == aliased_index(k)) begin
                dec.hit    = 1'b1;
                dec.sel[k] = 1'b1;
                dec.op     = OP_WRITE;
            end
            if (idx == aliased_index(k) + idx_t'(SET_OFS)) begin
                dec.hit     = 1'b1;
                dec.sel[k]  = 1'b1;
                dec.op      = OP_SET;
                dec.wr_only = 1'b1;
            end
            if (idx == aliased_index(k) + idx_t'(CLR_OFS)) begin
                dec.hit     = 1'b1;
                dec.sel[k]  = 1'b1;
                dec.op      = OP_CLR;
                dec.wr_only = 1'b1;
            end
        end
        for (int p = 0; p < NUM_PLAIN; p++) begin
            if (idx == plain_index(p)) begin
                dec.hit                  = 1'b1;
                dec.sel[NUM_ALIASED + p] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/crf_word.sv
module crf_word
    import crf_pkg::*;
#(
    parameter bit ALIASED = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  wr_op_e op,
    input  word_t  wdata,
    output word_t  q
);

    generate
        if (ALIASED) begin : g_alias
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we)
                    q <= merge(q, wdata, op);
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && op == OP_WRITE)
                    q <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/crf_resp.sv
module crf_resp
    import crf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  is_write,
    input  dec_t  dec,
    input  word_t rd_word,
    output logic  rsp_valid,
    output word_t rsp_rdata,
    output logic  rsp_err
);

    logic read_bad;
    assign read_bad = !dec.hit || dec.wr_only;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            if (is_write) begin
                rsp_rdata <= '0;
                rsp_err   <= !dec.hit;
            end else begin
                rsp_rdata <= read_bad ? '1 : rd_word;
                rsp_err   <= read_bad;
            end
        end else begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end
    end

endmodule

// File: rtl/chiplet_ctrl_regs.sv
module chiplet_ctrl_regs
    import crf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  rsp_err
);

    dec_t                        dec;
    idx_t                        idx;
    logic                        accept;
    logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
    word_t                       rd_word;
    logic                        unused_lsb;

    assign idx        = req_addr[ADDR_W-1:LSB_W];
    assign unused_lsb = ^req_addr[LSB_W-1:0];
    assign req_ready  = !rsp_valid;
    assign accept     = req_valid && req_ready;

    crf_decode u_dec (
        .idx (idx),
        .dec (dec)
    );

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        crf_word #(.ALIASED(k < NUM_ALIASED)) u_word (
            .clk   (clk),
            .rst   (rst),
            .we    (accept && req_write && dec.hit && dec.sel[k]),
            .op    (dec.op),
            .wdata (req_wdata),
            .q     (word_q[k])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_WORDS; k++)
            if (dec.sel[k])
                rd_word = rd_word | word_q[k];
    end

    crf_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .is_write  (req_write),
        .dec       (dec),
        .rd_word   (rd_word),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

endmodule

// File: rtl/crf_checker.sv
module crf_checker
    import crf_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          req_write,
    input logic                          rsp_valid,
    input logic [DATA_W-1:0]             rsp_rdata,
    input logic                          rsp_err,
    input logic [NUM_WORDS*DATA_W-1:0]   regs_flat
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (regs_flat == '0 && !rsp_valid));

    assert_ack_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_ack_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));

    assert_busy_during_ack_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_idle_keeps_state_R4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> $stable(regs_flat));

    assert_read_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> $stable(regs_flat));

    assert_bad_read_ones_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err && $past(!req_write)) |-> rsp_rdata == '1);

endmodule

bind chiplet_ctrl_regs crf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .regs_flat (word_q)
);

// File: tb/chiplet_ctrl_regs_test.sv
module chiplet_ctrl_regs_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [15:0] req_addr;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;

    int total = 0;
    int bad   = 0;
    logic [63:0] model [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    chiplet_ctrl_regs uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    // kind: 0 none, 1 plain, 2 set alias, 3 clear alias
    function automatic void classify(input int idx, output int kind, output int word);
        kind = 0;
        word = 0;
        for (int k = 0; k < 8; k++) begin
            int base;
            base = (k < 6) ? k : 8 + (k - 6);
            if (idx == base)      begin kind = 1; word = k; end
            if (idx == base + 16) begin kind = 2; word = k; end
            if (idx == base + 32) begin kind = 3; word = k; end
        end
        if (idx == 'h100) begin kind = 1; word = 8;  end
        if (idx == 'h101) begin kind = 1; word = 9;  end
        if (idx == 'h3FE) begin kind = 1; word = 10; end
        if (idx == 'h3FF) begin kind = 1; word = 11; end
    endfunction

    function automatic int word_index(input int w);
        if (w < 6)  return w;
        if (w < 8)  return 8 + w - 6;
        case (w)
            8:       return 'h100;
            9:       return 'h101;
            10:      return 'h3FE;
            default: return 'h3FF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int idx, input logic [2:0] lsb,
                          input logic [63:0] wd, output logic [63:0] rd, output logic err);
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R2", {62'd0, req_ready, rsp_valid}, 64'd2);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {idx[12:0], lsb};
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R2", {62'd0, req_ready, rsp_valid}, 64'd1);
        rd  = rsp_rdata;
        err = rsp_err;
    endtask

    task automatic wr_chk(input int idx, input logic [2:0] lsb, input logic [63:0] wd, input string req);
        logic [63:0] rd;
        logic        err;
        int kind, word;
        classify(idx, kind, word);
        access(1'b1, idx, lsb, wd, rd, err);
        if (kind == 1) model[word] = wd;
        if (kind == 2) model[word] = model[word] | wd;
        if (kind == 3) model[word] = model[word] & ~wd;
        chk(err === (kind == 0), req, {63'd0, err}, {63'd0, kind == 0});
        chk(rd === 64'd0, req, rd, 64'd0);
    endtask

    task automatic rd_chk(input int idx, input logic [2:0] lsb, input string req);
        logic [63:0] rd;
        logic        err;
        logic [63:0] exp;
        int kind, word;
        classify(idx, kind, word);
        access(1'b0, idx, lsb, 64'd0, rd, err);
        exp = (kind == 1) ? model[word] : '1;
        chk(rd === exp, req, rd, exp);
        chk(err === (kind != 1), req, {63'd0, err}, {63'd0, kind != 1});
    endtask

    task automatic check_all_words(input string req);
        for (int w = 0; w < 12; w++) rd_chk(word_index(w), 3'd0, req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int w = 0; w < 12; w++) model[w] = '0;
    endtask

    initial begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", {63'd0, req_ready}, 64'd1);
        chk(rsp_valid === 1'b0, "R1", {63'd0, rsp_valid}, 64'd0);
        check_all_words("R1");

        // R4, R7, R8: plain write and readback of every word
        for (int w = 0; w < 12; w++)
            wr_chk(word_index(w), 3'd0, {$urandom, $urandom}, "R4");
        for (int w = 0; w < 6; w++)  rd_chk(word_index(w), 3'd0, "R4");
        for (int w = 6; w < 8; w++)  rd_chk(word_index(w), 3'd0, "R7");
        for (int w = 8; w < 12; w++) rd_chk(word_index(w), 3'd0, "R8");

        // R5, R6: set and clear aliases on each aliased word
        for (int w = 0; w < 8; w++) begin
            wr_chk(word_index(w), 3'd0, 64'hF0F0_0000_FFFF_0001, "R5");
            wr_chk(word_index(w) + 'h10, 3'd0, 64'h0F00_1234_0000_8000, "R5");
            rd_chk(word_index(w), 3'd0, "R5");
            wr_chk(word_index(w) + 'h20, 3'd0, 64'h8000_0204_F000_0001, "R6");
            rd_chk(word_index(w), 3'd0, "R6");
            wr_chk(word_index(w) + 'h10, 3'd0, 64'd0, "R5");
            wr_chk(word_index(w) + 'h20, 3'd0, '1, "R6");
            rd_chk(word_index(w), 3'd0, "R6");
        end

        // R3: low address bits have no effect
        for (int l = 1; l < 8; l++) begin
            wr_chk(l % 6, 3'(l), {32'hA5A5_0000 + 32'(l), 32'h5A5A_FFFF}, "R3");
            rd_chk(l % 6, 3'(7 - l), "R3");
            rd_chk('h100 + (l % 2), 3'(l), "R3");
        end

        // R9: alias reads return ones with error, state untouched
        for (int w = 0; w < 8; w++) begin
            rd_chk(word_index(w) + 'h10, 3'd0, "R9");
            rd_chk(word_index(w) + 'h20, 3'd0, "R9");
        end
        check_all_words("R9");

        // R10: write every index up to 0x3FF and beyond with random data, then sweep reads
        for (int i = 0; i < 'h400; i++)
            wr_chk(i, 3'd0, {$urandom, $urandom}, "R10");
        for (int i = 0; i < 'h400; i++)
            rd_chk(i, 3'd0, "R10");
        for (int i = 0; i < 16; i++) begin
            wr_chk('h1000 + word_index(i % 12), 3'd0, '1, "R10");
            rd_chk('h0400 + word_index(i % 12), 3'd0, "R10");
        end
        check_all_words("R10");

        // R1: reset in the middle of a run
        do_reset();
        check_all_words("R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule